// File: doc/BRIEF.md
# Receive Frame Sync and Message Filter

This block sits behind the bit slicer and clock recovery of a slave-mode data receiver. A recovered serial bit stream comes in, qualified by a one-cycle bit-valid strobe. While the receiver is enabled and running, the block scans the stream without stopping. It looks for a programmable sync word that follows a run-in preamble. No wake-up pattern is searched for. Once the sync word is seen, the block can check a message identifier field if that check is enabled. It then shifts the payload into bytes and pushes them into a 16-entry byte FIFO. The downstream controller reads the FIFO.

Each recognition step raises its own one-cycle interrupt pulse: one for frame start, one for identifier match and one for end of message. A small write-only register port sets the receive-enable and mode bits. It also holds two configuration banks, A and B, and a bank-select bit. The bank contents and the select bit are copied into the working configuration only while the block is in sleep or hold. Changing them in the middle of a frame therefore cannot upset the state machine. Leaving hold goes straight to sync search. Leaving sleep first passes through a start-up wait.

Top module: `rx_frame_sync`

## Requirements
- R1: The block is running only when control bit 0 (hold request) is 0 and control bit 1 (receive enable) is 1. With receive enable 0 it is in sleep. With receive enable 1 and hold request 1 it is in hold. In sleep and in hold no interrupt is raised and no byte is written to the FIFO.
- R2: In sync search, on each bit-valid strobe, the block compares the newest N bits, MSB first, against the low N bits of the active sync word, where N = sync length field + 1. It does this once at least N bits have arrived since search began. On a match, irq_frame pulses in the cycle after the strobe that carried the last sync bit.
- R3: With identifier checking enabled, the next M bits after sync (M = identifier length field + 1, MSB first) are compared with the low M bits of the active identifier. A match pulses irq_id in the cycle after the last identifier bit. A mismatch drops the frame with no FIFO write and returns to sync search.
- R4: Payload bits after the sync word (and after the identifier, when it is checked) are grouped MSB first into bytes. Each completed byte is written to the FIFO.
- R5: When the programmed number of payload bytes (payload field + 1) has been written, irq_eom pulses together with the last write, and the block returns to sync search.
- R6: Writes to the bank-select bit (control bit 2: 0 selects A, 1 selects B) and to bank contents while running take no effect on the frame search. The active configuration is reloaded from the selected bank only in sleep or hold.
- R7: From hold with run requested, sync search starts on the next cycle. From sleep, sync search starts after STARTUP_CYC cycles of start-up wait, and bits arriving during the wait are not counted.
- R8: The FIFO holds 16 bytes, shows its oldest byte on fifo_data, pops on fifo_rd when not empty, and flags full and empty. After reset it is empty, not full and without overflow.
- R9: A write while the FIFO is full drops the byte and sets fifo_ovf, which stays set until reset.
- R10: The three interrupts are one-cycle pulses, and no two are high in the same cycle.
- R11: Register map on reg_addr: 0 is control. 1, 2 and 3 are bank A's sync word, identifier and lengths. 5, 6 and 7 are the same for bank B. The length word packs sync length - 1 in bits 3:0, identifier length - 1 in bits 7:4, payload bytes - 1 in bits 14:8, and identifier check enable in bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| bit_in | input | 1 | Recovered data bit |
| bit_vld | input | 1 | One-cycle strobe marking bit_in valid |
| fifo_rd | input | 1 | Pop the oldest FIFO byte |
| fifo_data | output | 8 | Oldest FIFO byte |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_ovf | output | 1 | Sticky overflow flag |
| irq_frame | output | 1 | Frame-start pulse |
| irq_id | output | 1 | Identifier-match pulse |
| irq_eom | output | 1 | End-of-message pulse |

## Verification
The bench builds the block with its defaults: a 16-entry FIFO and an 8-cycle start-up wait. Because a bit takes two clock cycles, a sync word sent right after wake from sleep loses exactly its first four bits. This separates the sleep and hold restarts. Bank A uses an 8-bit sync word and a 10-bit identifier, and bank B a 16-bit sync word with the identifier check off, so both length extremes and both identifier paths are reached. A 20-byte message in a 16-entry FIFO drives the full and overflow corner in one frame.

// File: rtl/rfs_pkg.sv
// Package: shared widths, state encoding and configuration record for the
// receive frame sync block. Assumes sync and identifier words of at most
// WORD_W bits.
package rfs_pkg;
    localparam int WORD_W  = 16;
    localparam int LEN_W   = $clog2(WORD_W);
    localparam int PAY_W   = 7;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_WARM  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_HUNT  = 3'd3,
        ST_IDCHK = 3'd4,
        ST_PAYLD = 3'd5
    } rfs_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] sync;
        logic [WORD_W-1:0] id;
        logic [LEN_W-1:0]  sync_m1;
        logic [LEN_W-1:0]  id_m1;
        logic [PAY_W-1:0]  pay_m1;
        logic              id_en;
    } rfs_cfg_t;

    // Mask covering the low (len_m1 + 1) bits of a word.
    function automatic logic [WORD_W-1:0] rfs_mask(input logic [LEN_W-1:0] len_m1);
        logic [2*WORD_W-1:0] t;
        t = {(2*WORD_W){1'b1}} << (int'(len_m1) + 1);
        return ~t[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/rfs_regs.sv
// Register bank: control bits, two configuration banks, and the active
// configuration copy. Assumes write-only access; the active copy follows the
// selected bank only while the controller reports sleep or hold.
module rfs_regs
    import rfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    input  rfs_state_e         st,
    output logic               rx_en,
    output logic               hold_req,
    output rfs_cfg_t           act_cfg
);
    localparam int NBANK = 2;

    logic [2:0] ctrl_q;
    rfs_cfg_t   bank_q [NBANK];

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctrl_q <= '0;
        else if (we && addr == '0)      ctrl_q <= wdata[2:0];
    end

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            // Bank g field writes: sync, identifier, packed lengths.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bank_q[g] <= '0;
                end else if (we && addr[2] == 1'(g)) begin
                    case (addr[1:0])
                        2'd1: bank_q[g].sync <= wdata;
                        2'd2: bank_q[g].id   <= wdata;
                        2'd3: begin
                            bank_q[g].sync_m1 <= wdata[3:0];
                            bank_q[g].id_m1   <= wdata[7:4];
                            bank_q[g].pay_m1  <= wdata[14:8];
                            bank_q[g].id_en   <= wdata[15];
                        end
                        default: ;
                    endcase
                end
            end
        end
    endgenerate

    // Reload the active configuration only in a quiet state.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   act_cfg <= '0;
        else if (st == ST_SLEEP || st == ST_HOLD)     act_cfg <= bank_q[ctrl_q[2]];
    end

    assign rx_en    = ctrl_q[1];
    assign hold_req = ctrl_q[0];
endmodule

// File: rtl/rfs_ctrl.sv
// Framing controller: shift register, sync search, identifier check and
// payload byte assembly with interrupt pulses. Assumes bit_vld is a
// single-cycle strobe and the configuration is stable outside sleep/hold.
module rfs_ctrl
    import rfs_pkg::*;
#(
    parameter int STARTUP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              hold_req,
    input  rfs_cfg_t          cfg,
    input  logic              bit_in,
    input  logic              bit_vld,
    output rfs_state_e        st,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              irq_frame,
    output logic              irq_id,
    output logic              irq_eom
);
    localparam int WCW = $clog2(STARTUP_CYC + 1);
    localparam int CW  = LEN_W + 1;

    rfs_state_e        st_q, st_d;
    logic [WORD_W-2:0] sh_q;
    logic [WORD_W-1:0] sh_nx;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [PAY_W-1:0]  byt_q, byt_d;
    logic [WCW-1:0]    wcnt_q, wcnt_d;
    logic              f_d, i_d, e_d, w_d;
    logic              sync_hit, id_hit;

    assign sh_nx    = {sh_q, bit_in};
    assign sync_hit = ((sh_nx ^ cfg.sync) & rfs_mask(cfg.sync_m1)) == '0;
    assign id_hit   = ((sh_nx ^ cfg.id) & rfs_mask(cfg.id_m1)) == '0;

    // Next-state, counter and event decode.
    always_comb begin
        st_d = st_q; cnt_d = cnt_q; byt_d = byt_q; wcnt_d = wcnt_q;
        f_d = 1'b0; i_d = 1'b0; e_d = 1'b0; w_d = 1'b0;
        if (!rx_en) begin
            st_d = ST_SLEEP;
        end else if (hold_req) begin
            st_d = ST_HOLD;
        end else begin
            case (st_q)
                ST_SLEEP: begin st_d = ST_WARM; wcnt_d = '0; end
                ST_WARM: begin
                    if (wcnt_q == WCW'(STARTUP_CYC - 1)) begin
                        st_d = ST_HUNT; cnt_d = '0;
                    end else begin
                        wcnt_d = wcnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin st_d = ST_HUNT; cnt_d = '0; end
                ST_HUNT: if (bit_vld) begin
                    if (cnt_q != CW'(WORD_W)) cnt_d = cnt_q + 1'b1;
                    if (cnt_q >= CW'(cfg.sync_m1) && sync_hit) begin
                        f_d = 1'b1; cnt_d = '0; byt_d = '0;
                        st_d = cfg.id_en ? ST_IDCHK : ST_PAYLD;
                    end
                end
                ST_IDCHK: if (bit_vld) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CW'(cfg.id_m1)) begin
                        cnt_d = '0;
                        if (id_hit) begin i_d = 1'b1; st_d = ST_PAYLD; end
                        else        st_d = ST_HUNT;
                    end
                end
                ST_PAYLD: if (bit_vld) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CW'(BYTE_W - 1)) begin
                        w_d = 1'b1; cnt_d = '0; byt_d = byt_q + 1'b1;
                        if (byt_q == cfg.pay_m1) begin e_d = 1'b1; st_d = ST_HUNT; end
                    end
                end
                default: st_d = ST_SLEEP;
            endcase
        end
    end

    // State, counters and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_SLEEP; cnt_q <= '0; byt_q <= '0; wcnt_q <= '0;
            irq_frame <= 1'b0; irq_id <= 1'b0; irq_eom <= 1'b0;
            wr_en <= 1'b0; wr_byte <= '0;
        end else begin
            st_q <= st_d; cnt_q <= cnt_d; byt_q <= byt_d; wcnt_q <= wcnt_d;
            irq_frame <= f_d; irq_id <= i_d; irq_eom <= e_d;
            wr_en <= w_d; wr_byte <= sh_nx[BYTE_W-1:0];
        end
    end

    // Serial shift register, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (bit_vld) sh_q <= sh_nx[WORD_W-2:0];
    end

    assign st = st_q;
endmodule

// File: rtl/rfs_fifo.sv
// Byte FIFO with show-ahead read, full/empty flags and a sticky overflow.
// Assumes a write is accepted only when not full at the clock edge.
module rfs_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty,
    output logic         ovf
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_wr, do_rd;

    assign full  = cnt_q == (AW+1)'(DEPTH);
    assign empty = cnt_q == '0;
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rp_q];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wdata;
    end

    // Pointers, occupancy and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0; rp_q <= '0; cnt_q <= '0; ovf <= 1'b0;
        end else begin
            if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
            else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
            if (wr && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_frame_sync.sv
// Top: receive frame sync and message filter. Connects the register bank,
// the framing controller and the payload FIFO. Assumes bit_in/bit_vld are
// synchronous to clk.
module rx_frame_sync
    import rfs_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int STARTUP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              fifo_rd,
    output logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              fifo_ovf,
    output logic              irq_frame,
    output logic              irq_id,
    output logic              irq_eom
);
    rfs_state_e        st_w;
    rfs_cfg_t          act_w;
    logic              rx_en_w, hold_w, wr_w;
    logic [BYTE_W-1:0] wbyte_w;

    rfs_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .st(st_w), .rx_en(rx_en_w), .hold_req(hold_w), .act_cfg(act_w)
    );

    rfs_ctrl #(.STARTUP_CYC(STARTUP_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en_w), .hold_req(hold_w), .cfg(act_w),
        .bit_in(bit_in), .bit_vld(bit_vld), .st(st_w), .wr_en(wr_w), .wr_byte(wbyte_w),
        .irq_frame(irq_frame), .irq_id(irq_id), .irq_eom(irq_eom)
    );

    rfs_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr(wr_w), .wdata(wbyte_w), .rd(fifo_rd),
        .rdata(fifo_data), .full(fifo_full), .empty(fifo_empty), .ovf(fifo_ovf)
    );
endmodule

// File: rtl/rfs_checker.sv
// Checker: temporal properties of the frame sync block, bound to the top.
module rfs_checker
    import rfs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       irq_frame,
    input logic       irq_id,
    input logic       irq_eom,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       fifo_ovf,
    input logic       fifo_rd,
    input logic       wr_en,
    input logic       rx_en,
    input logic       hold_req,
    input rfs_state_e st,
    input rfs_cfg_t   act_cfg
);
    // R1: interrupts only follow a cycle with run requested.
    a_r1_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_frame || irq_id || irq_eom) |-> $past(rx_en && !hold_req));
    // R2: a frame-start pulse coincides with leaving sync search.
    a_r2_frame_leaves_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        irq_frame |-> (st == ST_IDCHK || st == ST_PAYLD));
    // R6: active configuration frozen outside sleep and hold.
    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == ST_SLEEP || st == ST_HOLD) |=> $stable(act_cfg));
    // R7: hold restarts sync search on the next cycle.
    a_r7_hold_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && rx_en && !hold_req) |=> st == ST_HUNT);
    // R8: full and empty are exclusive.
    a_r8_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));
    // R9: overflow is sticky.
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf |=> fifo_ovf);
    // R9: write into a full FIFO leaves it full and flags overflow.
    a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_en && !fifo_rd) |=> (fifo_full && fifo_ovf));
    // R10: at most one interrupt per cycle.
    a_r10_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_frame, irq_id, irq_eom}));
endmodule

bind rx_frame_sync rfs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .irq_frame(irq_frame), .irq_id(irq_id), .irq_eom(irq_eom),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_ovf(fifo_ovf), .fifo_rd(fifo_rd),
    .wr_en(wr_w), .rx_en(rx_en_w), .hold_req(hold_w), .st(st_w), .act_cfg(act_w)
);

// File: tb/sim_rx_frame_sync.sv
// Bench: directed corner cases plus seeded random frames, checked against
// counts and bytes predicted by bench functions.
module sim_rx_frame_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        bit_in = 1'b0, bit_vld = 1'b0, fifo_rd = 1'b0;
    logic [7:0]  fifo_data;
    logic        fifo_full, fifo_empty, fifo_ovf, irq_frame, irq_id, irq_eom;

    int n_chk = 0, n_bad = 0;
    int n_f = 0, n_i = 0, n_e = 0;
    int x_f = 0, x_i = 0, x_e = 0;
    logic [7:0] pay [0:31];
    bit done = 1'b0;

    localparam logic [15:0] SYNC_A = 16'h00B5, ID_A = 16'h03C5, SYNC_B = 16'hE71A;

    always #5 clk = ~clk;

    rx_frame_sync u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .bit_in(bit_in), .bit_vld(bit_vld), .fifo_rd(fifo_rd), .fifo_data(fifo_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_ovf(fifo_ovf),
        .irq_frame(irq_frame), .irq_id(irq_id), .irq_eom(irq_eom)
    );

    // Interrupt pulse counters, sampled between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_frame) n_f++;
            if (irq_id)    n_i++;
            if (irq_eom)   n_e++;
        end
    end

    function automatic logic [15:0] lenword(input int slen, input int ilen, input int nbytes, input bit iden);
        return {iden, 7'(nbytes - 1), 4'(ilen - 1), 4'(slen - 1)};
    endfunction

    function automatic logic [15:0] ctrlword(input bit sel, input bit en, input bit hold);
        return {13'd0, sel, en, hold};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_in = b; bit_vld = 1'b1;
        @(negedge clk); bit_vld = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) send_bit(v[k]);
    endtask

    task automatic send_frame(input logic [15:0] s, input int sl, input logic [15:0] idv,
                              input int il, input int nb);
        send_bits(16'h00AA, 8);
        send_bits(s, sl);
        if (il > 0) send_bits(idv, il);
        for (int k = 0; k < nb; k++) send_bits({8'd0, pay[k]}, 8);
        repeat (3) @(negedge clk);
    endtask

    task automatic pop_check(input string req, input int nb);
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            chk(req, int'(fifo_data), int'(pay[k]));
            fifo_rd = 1'b1;
            @(negedge clk); fifo_rd = 1'b0;
        end
    endtask

    task automatic chk_irqs(input string req);
        chk({req, " frame"}, n_f, x_f);
        chk({req, " id"},    n_i, x_i);
        chk({req, " eom"},   n_e, x_e);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state.
        chk("R8 reset empty", fifo_empty, 1);
        chk("R8 reset full", fifo_full, 0);
        chk("R9 reset ovf", fifo_ovf, 0);
        chk("R10 reset irq", {irq_frame, irq_id, irq_eom}, 0);

        // R11: program banks through the register map.
        wr_reg(3'd1, SYNC_A); wr_reg(3'd2, ID_A); wr_reg(3'd3, lenword(8, 10, 3, 1'b1));
        wr_reg(3'd5, SYNC_B); wr_reg(3'd6, 16'h0000); wr_reg(3'd7, lenword(16, 1, 2, 1'b0));

        // R1: in hold, a full frame produces nothing.
        wr_reg(3'd0, ctrlword(1'b0, 1'b1, 1'b1));
        for (int k = 0; k < 3; k++) pay[k] = 8'(k + 1);
        send_frame(SYNC_A, 8, ID_A, 10, 3);
        chk_irqs("R1 hold");
        chk("R1 hold fifo empty", fifo_empty, 1);

        // R7: hold to run, sync without run-in is detected at once.
        wr_reg(3'd0, ctrlword(1'b0, 1'b1, 1'b0));
        send_bits(SYNC_A, 8);
        repeat (2) @(negedge clk);
        x_f++;
        chk("R7 hold restart frame", n_f, x_f);
        // R3 mismatch on this pending frame: wrong identifier drops it.
        send_bits(ID_A ^ 16'h0001, 10);
        repeat (3) @(negedge clk);
        chk_irqs("R3 mismatch");
        chk("R3 mismatch no write", fifo_empty, 1);

        // R2 R3 R4 R5: directed then random frames on bank A.
        for (int f = 0; f < 8; f++) begin
            logic [15:0] idv;
            bit good;
            good = (f < 2) || ($urandom % 3 != 0);
            idv = good ? ID_A : (ID_A ^ 16'(1 << ($urandom % 10)));
            for (int k = 0; k < 3; k++) pay[k] = 8'($urandom);
            if (f == 1) begin pay[0] = 8'h00; pay[1] = 8'hFF; pay[2] = 8'hB5; end
            send_frame(SYNC_A, 8, idv, 10, good ? 3 : 0);
            x_f++;
            if (good) begin x_i++; x_e++; end
            chk_irqs("R2 R3 R5 frame");
            if (good) pop_check("R4 payload byte", 3);
            chk("R5 fifo drained", fifo_empty, 1);
        end

        // R6: select B and change A length while running: no effect.
        wr_reg(3'd0, ctrlword(1'b1, 1'b1, 1'b0));
        wr_reg(3'd3, lenword(8, 10, 20, 1'b1));
        pay[0] = 8'h00; pay[1] = 8'h00;
        send_frame(SYNC_B, 16, 16'h0, 0, 2);
        chk_irqs("R6 bank B ignored");
        for (int k = 0; k < 3; k++) pay[k] = 8'($urandom);
        send_frame(SYNC_A, 8, ID_A, 10, 3);
        x_f++; x_i++; x_e++;
        chk_irqs("R6 bank A still active");
        pop_check("R6 three bytes", 3);

        // R6: through hold, bank B takes over (no identifier check).
        wr_reg(3'd0, ctrlword(1'b1, 1'b1, 1'b1));
        wr_reg(3'd0, ctrlword(1'b1, 1'b1, 1'b0));
        pay[0] = 8'h5A; pay[1] = 8'hC3;
        send_frame(SYNC_B, 16, 16'h0, 0, 2);
        x_f++; x_e++;
        chk_irqs("R6 bank B active");
        pop_check("R4 bank B byte", 2);

        // R8 R9: bank A with 20 bytes overflows the FIFO.
        wr_reg(3'd0, ctrlword(1'b0, 1'b1, 1'b1));
        wr_reg(3'd0, ctrlword(1'b0, 1'b1, 1'b0));
        for (int k = 0; k < 20; k++) pay[k] = 8'($urandom);
        send_frame(SYNC_A, 8, ID_A, 10, 20);
        x_f++; x_i++; x_e++;
        chk_irqs("R5 long frame");
        chk("R8 full", fifo_full, 1);
        chk("R9 overflow set", fifo_ovf, 1);
        pop_check("R9 first 16 kept", 16);
        chk("R8 empty after 16", fifo_empty, 1);
        chk("R9 overflow sticky", fifo_ovf, 1);

        // R7: from sleep the start-up wait swallows the first bits.
        wr_reg(3'd0, ctrlword(1'b0, 1'b0, 1'b0));
        wr_reg(3'd0, ctrlword(1'b0, 1'b1, 1'b0));
        send_bits(SYNC_A, 8);
        repeat (3) @(negedge clk);
        chk_irqs("R7 sleep warm-up");
        send_bits(SYNC_A, 8);
        repeat (2) @(negedge clk);
        x_f++;
        chk("R7 after warm-up", n_f, x_f);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule